// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry and Overflow Flags

This unit executes the whole family of fixed-point add and subtract operations of a 64-bit load/store core: register adds, subtract-from, the carrying and extended forms, the add-to-zero and add-minus-one extended forms, negate, and the immediate adds. Every operation is reduced to one 64-bit addition `src1 + src2 + cin`. The first operand may be inverted. The second operand is picked from the B register, the extended immediate, zero or all-ones. The carry-in is 0, 1 or the stored carry flag.

Along with the sum, the unit updates the fixed-point exception word. That word holds carry, overflow and sticky summary-overflow, plus the carry and overflow taken at the 32-bit boundary. The unit also produces a 4-bit condition field when recording is requested. Operations are accepted through a valid/ready pair. Results appear from one output register stage, one cycle after acceptance.

Top module: `fxu_addsub`

## Requirements
- R1: The operation code `op` selects `result = src1 + src2 + cin` modulo 2^64, as follows:
  - 0 add: `ra + rb`
  - 1 subtract-from: `~ra + rb + 1`
  - 2 add carrying: `ra + rb`
  - 3 subtract-from carrying: `~ra + rb + 1`
  - 4 add extended: `ra + rb + CA`
  - 5 subtract-from extended: `~ra + rb + CA`
  - 6 add minus-one extended: `ra + all-ones + CA`
  - 7 subtract-from minus-one extended: `~ra + all-ones + CA`
  - 8 add-to-zero extended: `ra + CA`
  - 9 subtract-from-zero extended: `~ra + CA`
  - 10 negate: `~ra + 1`
- R2: The immediate forms are:
  - 11 add immediate: `ra + simm`
  - 12 add shifted immediate: `ra + (simm << 16)`
  - 13 add immediate carrying: `ra + simm`
  - 14 add immediate carrying and record: `ra + simm`
  - 15 subtract-from immediate carrying: `~ra + simm + 1`

  Here `simm` is the 16-bit field sign-extended to 64 bits.
- R3: For codes 11 and 12 only, `ra_is_zero` = 1 replaces `ra` with 0. All other codes ignore `ra_is_zero`.
- R4: For codes 2 to 9 and 13 to 15, CA (exception bit 29) takes the carry out of bit 63, and CA32 (bit 18) takes the carry out of bit 31. For all other codes both bits are left unchanged.
- R5: For codes 0 to 10 with `oe` = 1, OV (bit 30) and OV32 (bit 19) take the signed overflow of the 64-bit and the low 32-bit sum, with the carry-in included. Otherwise OV and OV32 are left unchanged.
- R6: SO (bit 31) is set to 1 whenever OV is written with 1. In every other case SO keeps its input value.
- R7: All exception-word bits other than 31, 30, 29, 19 and 18 pass from `xer_in` to `xer_out` unchanged.
- R8: Recording is done when `rc` = 1 with a code from 0 to 10, or always with code 14. When recording, `cond` = {LT, GT, EQ, SO} (bit 3 down to bit 0):
  - exactly one of LT, GT, EQ is set, from a signed compare of the result with zero;
  - SO is the updated summary-overflow bit.

  Without recording, `cond` is 0000.
- R9: `in_ready` = !`out_valid` || `out_ready`. The outputs of an operation accepted on one edge are valid after that edge. While `out_valid` = 1 and `out_ready` = 0, the outputs hold steady.
- R10: During reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| op | input | 4 | Operation code (R1, R2) |
| ra | input | 64 | First source operand |
| rb | input | 64 | Second source operand |
| simm | input | 16 | Signed immediate field |
| ra_is_zero | input | 1 | Register field of the first source is zero |
| oe | input | 1 | Overflow update enable |
| rc | input | 1 | Condition record enable |
| xer_in | input | 32 | Current exception word |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 64 | Sum |
| xer_out | output | 32 | Updated exception word |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
A wrong decode entry or a wrong carry-in choice shows as a bad `result` or a bad flag in the very next output cycle, because the unit keeps no state between operations apart from the output register. Faults at the 32-bit boundary are exposed by operands at the sign edges 0x7FFFFFFF and 0x80000000 and at all-ones. Inversion and carry-in faults are exposed by running each extended form with the stored carry both clear and set. A corrupted output register under back-pressure shows as a result that changes while `out_valid` is held without `out_ready`.

// File: rtl/fxu_pkg.sv
package fxu_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,  OP_SUBF   = 4'd1,  OP_ADDC  = 4'd2,  OP_SUBFC  = 4'd3,
    OP_ADDE   = 4'd4,  OP_SUBFE  = 4'd5,  OP_ADDME = 4'd6,  OP_SUBFME = 4'd7,
    OP_ADDZE  = 4'd8,  OP_SUBFZE = 4'd9,  OP_NEG   = 4'd10, OP_ADDI   = 4'd11,
    OP_ADDIS  = 4'd12, OP_ADDIC  = 4'd13, OP_ADDICR = 4'd14, OP_SUBFIC = 4'd15
  } fxu_op_e;

  typedef enum logic [1:0] {S2_REG, S2_IMM, S2_ZERO, S2_ONES} src2_e;
  typedef enum logic [1:0] {CI_ZERO, CI_ONE, CI_CA} cin_e;

  typedef struct packed {
    logic  inv_a;
    src2_e src2;
    logic  imm_shift;
    cin_e  cin;
    logic  ca_upd;
    logic  oe_ok;
    logic  rc_ok;
    logic  rc_force;
    logic  ra0_ok;
  } fxu_ctl_t;

  localparam int XB_SO   = 31;
  localparam int XB_OV   = 30;
  localparam int XB_CA   = 29;
  localparam int XB_OV32 = 19;
  localparam int XB_CA32 = 18;

endpackage

// File: rtl/fxu_decode.sv
module fxu_decode
  import fxu_pkg::*;
(
  input  fxu_op_e  op,
  output fxu_ctl_t ctl
);
  always_comb begin
    ctl = '{inv_a: 1'b0, src2: S2_REG, imm_shift: 1'b0, cin: CI_ZERO,
            ca_upd: 1'b0, oe_ok: 1'b1, rc_ok: 1'b1, rc_force: 1'b0, ra0_ok: 1'b0};
    case (op)
      OP_ADD:    ;
      OP_SUBF:   begin ctl.inv_a = 1'b1; ctl.cin = CI_ONE; end
      OP_ADDC:   ctl.ca_upd = 1'b1;
      OP_SUBFC:  begin ctl.inv_a = 1'b1; ctl.cin = CI_ONE; ctl.ca_upd = 1'b1; end
      OP_ADDE:   begin ctl.cin = CI_CA; ctl.ca_upd = 1'b1; end
      OP_SUBFE:  begin ctl.inv_a = 1'b1; ctl.cin = CI_CA; ctl.ca_upd = 1'b1; end
      OP_ADDME:  begin ctl.src2 = S2_ONES; ctl.cin = CI_CA; ctl.ca_upd = 1'b1; end
      OP_SUBFME: begin ctl.inv_a = 1'b1; ctl.src2 = S2_ONES; ctl.cin = CI_CA; ctl.ca_upd = 1'b1; end
      OP_ADDZE:  begin ctl.src2 = S2_ZERO; ctl.cin = CI_CA; ctl.ca_upd = 1'b1; end
      OP_SUBFZE: begin ctl.inv_a = 1'b1; ctl.src2 = S2_ZERO; ctl.cin = CI_CA; ctl.ca_upd = 1'b1; end
      OP_NEG:    begin ctl.inv_a = 1'b1; ctl.src2 = S2_ZERO; ctl.cin = CI_ONE; end
      default: begin
        ctl.src2  = S2_IMM;
        ctl.oe_ok = 1'b0;
        ctl.rc_ok = 1'b0;
        case (op)
          OP_ADDI:   ctl.ra0_ok = 1'b1;
          OP_ADDIS:  begin ctl.ra0_ok = 1'b1; ctl.imm_shift = 1'b1; end
          OP_ADDIC:  ctl.ca_upd = 1'b1;
          OP_ADDICR: begin ctl.ca_upd = 1'b1; ctl.rc_force = 1'b1; end
          default:   begin ctl.inv_a = 1'b1; ctl.cin = CI_ONE; ctl.ca_upd = 1'b1; end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/fxu_adder.sv
module fxu_adder #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         co_full,
  output logic         co_half,
  output logic         ov_full,
  output logic         ov_half
);
  localparam int H = W / 2;

  logic [W:0] full_sum;
  logic [H:0] half_sum;

  always_comb begin
    full_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    half_sum = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
    sum      = full_sum[W-1:0];
    co_full  = full_sum[W];
    co_half  = half_sum[H];
    ov_full  = (a[W-1] == b[W-1]) && (full_sum[W-1] != a[W-1]);
    ov_half  = (a[H-1] == b[H-1]) && (half_sum[H-1] != a[H-1]);
  end
endmodule

// File: rtl/fxu_flags.sv
module fxu_flags
  import fxu_pkg::*;
#(
  parameter int W  = 64,
  parameter int XW = 32
) (
  input  fxu_ctl_t      ctl,
  input  logic          oe,
  input  logic          rc,
  input  logic [XW-1:0] xer_in,
  input  logic [W-1:0]  sum,
  input  logic          co_full,
  input  logic          co_half,
  input  logic          ov_full,
  input  logic          ov_half,
  output logic [XW-1:0] xer_out,
  output logic [3:0]    cond
);
  logic rec, neg, zero;

  always_comb begin
    xer_out = xer_in;
    if (ctl.ca_upd) begin
      xer_out[XB_CA]   = co_full;
      xer_out[XB_CA32] = co_half;
    end
    if (oe && ctl.oe_ok) begin
      xer_out[XB_OV]   = ov_full;
      xer_out[XB_OV32] = ov_half;
      xer_out[XB_SO]   = xer_in[XB_SO] | ov_full;
    end
    rec  = ctl.rc_force | (rc & ctl.rc_ok);
    neg  = sum[W-1];
    zero = (sum == '0);
    cond = rec ? {neg, ~neg & ~zero, zero, xer_out[XB_SO]} : 4'b0000;
  end
endmodule

// File: rtl/fxu_addsub.sv
module fxu_addsub
  import fxu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 16,
  parameter int XERW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] ra,
  input  logic [XLEN-1:0] rb,
  input  logic [IMMW-1:0] simm,
  input  logic            ra_is_zero,
  input  logic            oe,
  input  logic            rc,
  input  logic [XERW-1:0] xer_in,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] result,
  output logic [XERW-1:0] xer_out,
  output logic [3:0]      cond
);
  localparam logic [XERW-1:0] FLAG_MASK = (XERW'(1) << XB_SO) | (XERW'(1) << XB_OV) |
                                          (XERW'(1) << XB_CA) | (XERW'(1) << XB_OV32) |
                                          (XERW'(1) << XB_CA32);

  fxu_ctl_t        ctl;
  logic [XLEN-1:0] imm_ext, src1_base, src1, src2, sum;
  logic            cin, co_full, co_half, ov_full, ov_half, fire, vld_d;
  logic [XERW-1:0] xer_d;
  logic [3:0]      cond_d;

  fxu_decode u_dec (.op(fxu_op_e'(op)), .ctl(ctl));

  always_comb begin
    imm_ext   = {{(XLEN-IMMW){simm[IMMW-1]}}, simm};
    src1_base = (ctl.ra0_ok && ra_is_zero) ? '0 : ra;
    src1      = ctl.inv_a ? ~src1_base : src1_base;
    case (ctl.src2)
      S2_REG:  src2 = rb;
      S2_IMM:  src2 = ctl.imm_shift ? (imm_ext << IMMW) : imm_ext;
      S2_ZERO: src2 = '0;
      default: src2 = '1;
    endcase
    case (ctl.cin)
      CI_ZERO: cin = 1'b0;
      CI_ONE:  cin = 1'b1;
      default: cin = xer_in[XB_CA];
    endcase
  end

  fxu_adder #(.W(XLEN)) u_add (
    .a(src1), .b(src2), .cin(cin), .sum(sum),
    .co_full(co_full), .co_half(co_half), .ov_full(ov_full), .ov_half(ov_half)
  );

  fxu_flags #(.W(XLEN), .XW(XERW)) u_flg (
    .ctl(ctl), .oe(oe), .rc(rc), .xer_in(xer_in), .sum(sum),
    .co_full(co_full), .co_half(co_half), .ov_full(ov_full), .ov_half(ov_half),
    .xer_out(xer_d), .cond(cond_d)
  );

  always_comb begin
    in_ready = ~out_valid | out_ready;
    fire     = in_valid & in_ready;
    vld_d    = fire | (out_valid & ~out_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      result  <= sum;
      xer_out <= xer_d;
      cond    <= cond_d;
    end
  end

  assert_xer_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((xer_out ^ $past(xer_in)) & ~FLAG_MASK) == '0);

  assert_so_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && xer_in[XB_SO] |=> xer_out[XB_SO]);

  assert_ca_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !ctl.ca_upd |=> xer_out[XB_CA] == $past(xer_in[XB_CA]));

  assert_cond_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (cond != 4'b0000) |-> $countones(cond[3:1]) == 1);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(xer_out) && $stable(cond));

endmodule

// File: tb/fxu_addsub_tb.sv
module fxu_addsub_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1, in_ready, out_valid;
  logic [3:0]  op = '0;
  logic [63:0] ra = '0, rb = '0, result;
  logic [15:0] simm = '0;
  logic        ra_is_zero = 1'b0, oe = 1'b0, rc = 1'b0;
  logic [31:0] xer_in = '0, xer_out;
  logic [3:0]  cond;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  fxu_addsub dut_i (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] o, input logic [63:0] a, b, input logic [15:0] im,
                       input logic z, e, r, input logic [31:0] x,
                       output logic [63:0] res, output logic [31:0] xo, output logic [3:0] cr);
    logic [63:0] s1, s2, ie;
    logic c, cu, ovok, rec;
    logic [64:0] f; logic [32:0] l;
    logic signed [64:0] sx; logic signed [32:0] sl;
    ie = {{48{im[15]}}, im};
    cu = 1'b1; ovok = (o <= 4'd10); rec = (r && o <= 4'd10) || o == 4'd14;
    case (o)
      0:  begin s1 = a;  s2 = b;   c = 0; cu = 0; end
      1:  begin s1 = ~a; s2 = b;   c = 1; cu = 0; end
      2:  begin s1 = a;  s2 = b;   c = 0; end
      3:  begin s1 = ~a; s2 = b;   c = 1; end
      4:  begin s1 = a;  s2 = b;   c = x[29]; end
      5:  begin s1 = ~a; s2 = b;   c = x[29]; end
      6:  begin s1 = a;  s2 = '1;  c = x[29]; end
      7:  begin s1 = ~a; s2 = '1;  c = x[29]; end
      8:  begin s1 = a;  s2 = '0;  c = x[29]; end
      9:  begin s1 = ~a; s2 = '0;  c = x[29]; end
      10: begin s1 = ~a; s2 = '0;  c = 1; cu = 0; end
      11: begin s1 = z ? '0 : a; s2 = ie; c = 0; cu = 0; end
      12: begin s1 = z ? '0 : a; s2 = {ie[47:0], 16'h0}; c = 0; cu = 0; end
      13: begin s1 = a;  s2 = ie;  c = 0; end
      14: begin s1 = a;  s2 = ie;  c = 0; end
      default: begin s1 = ~a; s2 = ie; c = 1; end
    endcase
    f  = {1'b0, s1} + {1'b0, s2} + 65'(c);
    l  = {1'b0, s1[31:0]} + {1'b0, s2[31:0]} + 33'(c);
    sx = $signed({s1[63], s1}) + $signed({s2[63], s2}) + $signed({64'd0, c});
    sl = $signed({s1[31], s1[31:0]}) + $signed({s2[31], s2[31:0]}) + $signed({32'd0, c});
    res = f[63:0];
    xo = x;
    if (cu) begin xo[29] = f[64]; xo[18] = l[32]; end
    if (e && ovok) begin
      xo[30] = sx[64] ^ sx[63]; xo[19] = sl[32] ^ sl[31];
      if (xo[30]) xo[31] = 1'b1;
    end
    if (!rec) cr = 4'b0;
    else cr = {res[63], !res[63] && res != 0, res == 0, xo[31]};
  endtask

  task automatic run_op(string tag, logic [3:0] o, logic [63:0] a, b, logic [15:0] im,
                        logic z, e, r, logic [31:0] x);
    logic [63:0] er; logic [31:0] ex; logic [3:0] ec;
    model(o, a, b, im, z, e, r, x, er, ex, ec);
    @(negedge clk);
    op = o; ra = a; rb = b; simm = im; ra_is_zero = z; oe = e; rc = r; xer_in = x;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R1 result"}, result, er);
    chk("R4 R5 R6 R7 xer", 64'(xer_out), 64'(ex));
    chk("R8 cond", 64'(cond), 64'(ec));
  endtask

  logic [63:0] corners [6] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
                               64'h8000_0000_0000_0000, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000};
  logic [15:0] imms [5] = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF};

  task automatic t_reg_forms();
    for (int o = 0; o <= 10; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j += 2)
          for (int c = 0; c < 2; c++)
            run_op("R1", 4'(o), corners[i], corners[j], 16'h0, 1'b0, 1'b1, 1'b1,
                   c ? 32'h2000_0000 : 32'h0);
  endtask

  task automatic t_imm_forms();
    for (int o = 11; o <= 15; o++)
      for (int i = 0; i < 6; i++)
        for (int k = 0; k < 5; k++)
          run_op("R2", 4'(o), corners[i], 64'h5, imms[k], 1'b0, 1'b1, 1'b1, 32'h0);
  endtask

  task automatic t_ra_zero();
    run_op("R3", 4'd11, 64'h1234, 64'h0, 16'h8001, 1'b1, 1'b0, 1'b0, 32'h0);
    run_op("R3", 4'd12, 64'h1234, 64'h0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 32'h0);
    run_op("R3", 4'd13, 64'h1234, 64'h0, 16'h0002, 1'b1, 1'b0, 1'b0, 32'h0);
    run_op("R3", 4'd0,  64'h1234, 64'h1, 16'h0, 1'b1, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_flag_keep();
    run_op("R5", 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 1'b0, 1'b0, 1'b0, 32'h0);
    run_op("R5", 4'd0, 64'h1, 64'h1, 16'h0, 1'b0, 1'b0, 1'b0, 32'h4008_0000);
    run_op("R6", 4'd0, 64'h1, 64'h1, 16'h0, 1'b0, 1'b1, 1'b1, 32'h8000_0000);
    run_op("R6", 4'd2, 64'h1, 64'h1, 16'h0, 1'b0, 1'b1, 1'b1, 32'hC008_0000);
    run_op("R7", 4'd3, 64'h5, 64'h3, 16'h0, 1'b0, 1'b1, 1'b1, 32'h1A5A_5A5A);
    run_op("R7", 4'd15, 64'h9, 64'h0, 16'hFFF0, 1'b0, 1'b1, 1'b0, 32'h0FF3_FFFF);
  endtask

  task automatic t_stall();
    logic [63:0] er; logic [31:0] ex; logic [3:0] ec;
    @(negedge clk);
    out_ready = 1'b0; op = 4'd0; ra = 64'd10; rb = 64'd20; oe = 1'b0; rc = 1'b0;
    xer_in = 32'h0; in_valid = 1'b1;
    @(negedge clk);
    chk("R9 valid after accept", 64'(out_valid), 64'd1);
    chk("R9 ready low while stalled", 64'(in_ready), 64'd0);
    ra = 64'd100; rb = 64'd1;
    @(negedge clk);
    chk("R9 held result", result, 64'd30);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(4'd0, 64'd100, 64'd1, 16'h0, 1'b0, 1'b0, 1'b0, 32'h0, er, ex, ec);
    chk("R9 next result", result, er);
    @(negedge clk);
    chk("R9 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog expired act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #23;
    chk("R10 reset out_valid", 64'(out_valid), 64'd0);
    chk("R10 reset in_ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    t_reg_forms();
    t_imm_forms();
    t_ra_zero();
    t_flag_keep();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule